// File: doc/BRIEF.md
# AUX Request Command Packer

This block turns a host request (a 20-bit target address, a read/write flag, a native-or-I2C flag, a byte count and, for writes, a stream of payload bytes) into the word sequence a DisplayPort AUX command FIFO expects. It pushes a four-byte header and then any payload bytes. It then pulses a start strobe that carries the transaction-control flags. For reads, it waits until the link reports that the reply has landed. It then pops the reply from the FIFO, discards the leading word, and hands out each data byte with a flag that reports whether the byte's position tag was wrong.

Requests are taken over a valid/ready handshake, and only while the block is idle. Requests that cannot be carried are settled in the cycle they are presented. An empty request is acknowledged at once. An oversized request is refused. In both cases nothing reaches the FIFO. Payload bytes arrive on their own valid/ready port and may stall. Each accepted byte is written to the FIFO in the cycle it is taken.

Top module: `aux_req_packer`

## Requirements
- R1: Header byte 0 holds address bits 19:16 in bits 3:0 and the read flag in bit 4 (1 = read, 0 = write), with bits 7:5 zero.
- R2: Header byte 1 holds address bits 15:8, byte 2 holds address bits 7:0, and byte 3 holds the byte count minus one.
- R3: A read pushes exactly the four header bytes. A write pushes the header and then every payload byte, in arrival order.
- R4: A write whose header plus payload would exceed 128 FIFO words is refused: `req_refused` is high in the presenting cycle, and no FIFO write and no start strobe follow.
- R5: The first word of every request carries `cmd_idx_rst` = 1, and every later word of that request carries 0.
- R6: A native request of more than 16 bytes, or an I2C request of more than 128 bytes, is refused. A zero-byte request raises `req_ack` in its presenting cycle and sends nothing.
- R7: The start strobe `ctl_go` lasts exactly one cycle. With it, `ctl_i2c` is 1 for I2C requests, and `ctl_no_addr`/`ctl_no_stop` copy the request's flags. For native requests all three are 0.
- R8: After `link_done`, the block pops the reply words. The first popped word is discarded. Each following word gives a byte on `rep_data` (word bits 7:0), in order. `rep_idx_err` is high for a byte whose index field (word bits 15:8) differs from its 0-based position.
- R9: `req_ready` is high only when idle. It returns after the start strobe for a write, or after the last reply byte for a read. While it is high there are no FIFO writes, pops or strobes.
- R10: While `pay_valid` is low during the payload phase, nothing is written and the block waits without losing bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_native | input | 1 | 1 = native, 0 = I2C |
| req_no_addr | input | 1 | I2C: suppress address phase |
| req_no_stop | input | 1 | I2C: suppress stop |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Byte count |
| req_ack | output | 1 | Zero-byte request acknowledged |
| req_refused | output | 1 | Request refused for length |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Payload byte |
| cmd_wr | output | 1 | FIFO write strobe |
| cmd_wdata | output | 8 | FIFO write byte |
| cmd_idx_rst | output | 1 | Restart FIFO write index at 0 |
| ctl_go | output | 1 | Start strobe |
| ctl_i2c | output | 1 | I2C transaction flag |
| ctl_no_addr | output | 1 | No-send-address flag |
| ctl_no_stop | output | 1 | No-send-stop flag |
| link_done | input | 1 | Reply has arrived in the FIFO |
| fifo_rd_en | output | 1 | Pop reply word |
| fifo_rd_data | input | 16 | Reply word at head (show-ahead) |
| rep_valid | output | 1 | Reply byte valid |
| rep_data | output | 8 | Reply byte |
| rep_idx_err | output | 1 | Reply byte index mismatch |

## Verification
The assertions take for granted that `fifo_rd_data` shows the head word combinationally, so that a pop and its data belong to the same cycle. They also take for granted that `link_done` is raised only after the start strobe of a read. The bench models the FIFO as a show-ahead array advanced on each pop, and pulses `link_done` only once it has seen the strobe. It never presents `req_valid` except while `req_ready` is high.

// File: rtl/aux_req_packer.sv
module aux_req_packer #(
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int FIFO_LIMIT = 128,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic             req_native,
  input  logic             req_no_addr,
  input  logic             req_no_stop,
  input  logic [19:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ack,
  output logic             req_refused,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic [7:0]       pay_data,
  output logic             cmd_wr,
  output logic [7:0]       cmd_wdata,
  output logic             cmd_idx_rst,
  output logic             ctl_go,
  output logic             ctl_i2c,
  output logic             ctl_no_addr,
  output logic             ctl_no_stop,
  input  logic             link_done,
  output logic             fifo_rd_en,
  input  logic [15:0]      fifo_rd_data,
  output logic             rep_valid,
  output logic [7:0]       rep_data,
  output logic             rep_idx_err
);
  localparam int HDR_BYTES = 4;
  localparam int CNT_W     = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_GO, S_WAIT, S_SKIP, S_DRAIN} st_t;
  st_t st;

  logic             r_read, r_native, r_no_addr, r_no_stop;
  logic [19:0]      r_addr;
  logic [LEN_W-1:0] r_len;
  logic [CNT_W-1:0] cnt;

  logic [CNT_W-1:0] len_x, last_pos;
  logic             zero_len, too_big, take;

  assign len_x    = {1'b0, req_len};
  assign last_pos = {1'b0, r_len} - 1'b1;
  assign zero_len = (req_len == '0);
  assign too_big  = (req_native && len_x > CNT_W'(NATIVE_MAX)) ||
                    (len_x > CNT_W'(I2C_MAX)) ||
                    (!req_read && (len_x + CNT_W'(HDR_BYTES)) > CNT_W'(FIFO_LIMIT));

  assign req_ready   = (st == S_IDLE);
  assign req_ack     = req_ready && req_valid && zero_len;
  assign req_refused = req_ready && req_valid && !zero_len && too_big;
  assign take        = req_ready && req_valid && !zero_len && !too_big;

  assign pay_ready   = (st == S_PAY);
  assign cmd_wr      = (st == S_HDR) || (pay_ready && pay_valid);
  assign cmd_idx_rst = (st == S_HDR) && (cnt == '0);

  always_comb begin
    cmd_wdata = pay_data;
    if (st == S_HDR) begin
      case (cnt[1:0])
        2'd0:    cmd_wdata = {3'b000, r_read, r_addr[19:16]};
        2'd1:    cmd_wdata = r_addr[15:8];
        2'd2:    cmd_wdata = r_addr[7:0];
        default: cmd_wdata = 8'(r_len - 1'b1);
      endcase
    end
  end

  assign ctl_go      = (st == S_GO);
  assign ctl_i2c     = ctl_go && !r_native;
  assign ctl_no_addr = ctl_i2c && r_no_addr;
  assign ctl_no_stop = ctl_i2c && r_no_stop;

  assign fifo_rd_en  = (st == S_SKIP) || (st == S_DRAIN);
  assign rep_valid   = (st == S_DRAIN);
  assign rep_data    = fifo_rd_data[7:0];
  assign rep_idx_err = rep_valid && (fifo_rd_data[15:8] != cnt[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      r_read    <= 1'b0;
      r_native  <= 1'b0;
      r_no_addr <= 1'b0;
      r_no_stop <= 1'b0;
      r_addr    <= '0;
      r_len     <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          r_read    <= req_read;
          r_native  <= req_native;
          r_no_addr <= req_no_addr;
          r_no_stop <= req_no_stop;
          r_addr    <= req_addr;
          r_len     <= req_len;
          cnt       <= '0;
          st        <= S_HDR;
        end
        S_HDR: begin
          if (cnt == CNT_W'(HDR_BYTES - 1)) begin
            cnt <= '0;
            st  <= r_read ? S_GO : S_PAY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAY: if (pay_valid) begin
          if (cnt == last_pos) begin
            cnt <= '0;
            st  <= S_GO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GO:   st <= r_read ? S_WAIT : S_IDLE;
        S_WAIT: if (link_done) st <= S_SKIP;
        S_SKIP: begin
          cnt <= '0;
          st  <= S_DRAIN;
        end
        S_DRAIN: begin
          if (cnt == last_pos) st <= S_IDLE;
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_req_packer_chk.sv
module aux_req_packer_chk #(
  parameter int FIFO_LIMIT = 128
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic req_ack,
  input logic req_refused,
  input logic cmd_wr,
  input logic cmd_idx_rst,
  input logic ctl_go,
  input logic ctl_i2c,
  input logic ctl_no_addr,
  input logic ctl_no_stop,
  input logic fifo_rd_en,
  input logic rep_valid
);
  logic [15:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    wr_cnt <= '0;
    else if (cmd_wr && cmd_idx_rst) wr_cnt <= 16'd1;
    else if (cmd_wr)               wr_cnt <= wr_cnt + 16'd1;
  end

  AST_FIRST_WORD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_idx_rst == $past(req_ready)));  // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_wr && !ctl_go && !fifo_rd_en));  // R9
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_go |=> !ctl_go);  // R7
  AST_NATIVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && !ctl_i2c) |-> (!ctl_no_addr && !ctl_no_stop));  // R7
  AST_SETTLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_refused || req_ack) |=> (req_ready && !cmd_wr));  // R4, R6
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_go |-> (wr_cnt >= 16'd4 && wr_cnt <= 16'(FIFO_LIMIT)));  // R4
  AST_REPLY_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> fifo_rd_en);  // R8
endmodule

bind aux_req_packer aux_req_packer_chk #(.FIFO_LIMIT(FIFO_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_ack(req_ack),
  .req_refused(req_refused), .cmd_wr(cmd_wr), .cmd_idx_rst(cmd_idx_rst),
  .ctl_go(ctl_go), .ctl_i2c(ctl_i2c), .ctl_no_addr(ctl_no_addr),
  .ctl_no_stop(ctl_no_stop), .fifo_rd_en(fifo_rd_en), .rep_valid(rep_valid)
);

// File: tb/aux_req_packer_bench.sv
`timescale 1ns/1ps
module aux_req_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_read = 0, req_native = 0, req_no_addr = 0, req_no_stop = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic pay_valid = 0;
  logic [7:0] pay_data = '0;
  logic link_done = 0;
  logic req_ready, req_ack, req_refused, pay_ready, cmd_wr, cmd_idx_rst;
  logic [7:0] cmd_wdata, rep_data;
  logic ctl_go, ctl_i2c, ctl_no_addr, ctl_no_stop, fifo_rd_en, rep_valid, rep_idx_err;
  logic [15:0] fifo_rd_data;

  logic [15:0] rdmem [0:255];
  int rptr;
  assign fifo_rd_data = rdmem[rptr[7:0]];

  aux_req_packer u_aux_req_packer (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] wmem [0:255];
  logic [7:0] pl [0:255];
  int wptr, wr_total, rst_flags, go_cnt;
  logic go_i2c, go_na, go_ns;
  logic [7:0] rep_buf [0:255];
  logic rep_err_buf [0:255];
  int rep_n;
  logic got_ack, got_ref;

  always @(posedge clk) begin
    if (cmd_wr) begin
      wr_total <= wr_total + 1;
      if (cmd_idx_rst) begin
        rst_flags <= rst_flags + 1;
        wmem[0] <= cmd_wdata;
        wptr <= 1;
      end else begin
        wmem[wptr[7:0]] <= cmd_wdata;
        wptr <= wptr + 1;
      end
    end
    if (ctl_go) begin
      go_cnt <= go_cnt + 1;
      go_i2c <= ctl_i2c; go_na <= ctl_no_addr; go_ns <= ctl_no_stop;
    end
    if (fifo_rd_en) rptr <= rptr + 1;
    if (rep_valid) begin
      rep_buf[rep_n[7:0]] <= rep_data;
      rep_err_buf[rep_n[7:0]] <= rep_idx_err;
      rep_n <= rep_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    @(negedge clk);
    wptr = 0; wr_total = 0; rst_flags = 0; go_cnt = 0; rptr = 0; rep_n = 0;
  endtask

  task automatic send_req(input bit rd, input bit nat, input bit na, input bit ns,
                          input logic [19:0] a, input int len);
    @(negedge clk);
    req_read = rd; req_native = nat; req_no_addr = na; req_no_stop = ns;
    req_addr = a; req_len = 8'(len); req_valid = 1;
    #1;
    got_ack = req_ack; got_ref = req_refused;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic check_header(input bit rd, input logic [19:0] a, input int len);
    chk(wmem[0] == {3'b000, rd, a[19:16]}, "R1 header byte0", wmem[0], {3'b000, rd, a[19:16]});
    chk(wmem[1] == a[15:8], "R2 header byte1", wmem[1], a[15:8]);
    chk(wmem[2] == a[7:0], "R2 header byte2", wmem[2], a[7:0]);
    chk(wmem[3] == 8'(len - 1), "R2 header byte3", wmem[3], len - 1);
    chk(rst_flags == 1, "R5 single index reset", rst_flags, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R9 ready after reset", req_ready, 1);
    chk(cmd_wr == 0 && ctl_go == 0 && fifo_rd_en == 0, "R9 quiet after reset",
        {cmd_wr, ctl_go, fifo_rd_en}, 0);
  endtask

  task automatic t_write(input bit nat, input bit na, input bit ns, input logic [19:0] a,
                         input int len, input bit stall);
    int bad = 0;
    clear_cap();
    for (int i = 0; i < len; i++) pl[i] = 8'(i * 37 + a[7:0] + 5);
    send_req(1'b0, nat, na, ns, a, len);
    chk(!got_ref && !got_ack, "R4 legal write taken", {got_ref, got_ack}, 0);
    for (int i = 0; i < len; i++) begin
      if (stall && (i % 3 == 1)) begin
        pay_valid = 0;
        repeat (3) @(negedge clk);
        chk(wr_total == 4 + i, "R10 no write while stalled", wr_total, 4 + i);
      end
      pay_valid = 1; pay_data = pl[i];
      while (!pay_ready) @(negedge clk);
      @(negedge clk);
      pay_valid = 0;
    end
    wait_idle();
    check_header(1'b0, a, len);
    chk(wr_total == 4 + len, "R3 write word count", wr_total, 4 + len);
    for (int i = 0; i < len; i++) if (wmem[4 + i] != pl[i]) bad++;
    chk(bad == 0, "R3 payload order", bad, 0);
    chk(go_cnt == 1, "R7 one start strobe", go_cnt, 1);
    chk(go_i2c == !nat && go_na == (!nat && na) && go_ns == (!nat && ns),
        "R7 control flags", {go_i2c, go_na, go_ns}, {!nat, !nat && na, !nat && ns});
  endtask

  task automatic t_read(input bit nat, input logic [19:0] a, input int len, input int bad_pos);
    int bad = 0, errs = 0;
    clear_cap();
    rdmem[0] = 16'hA55A;
    for (int k = 0; k < len; k++)
      rdmem[k + 1] = {(k == bad_pos) ? 8'(k + 1) : 8'(k), 8'(k * 11 + 3)};
    send_req(1'b1, nat, 1'b1, 1'b0, a, len);
    chk(!got_ref && !got_ack, "R6 legal read taken", {got_ref, got_ack}, 0);
    while (go_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req_ready == 0 && rep_n == 0, "R9 busy until reply", req_ready, 0);
    link_done = 1;
    @(negedge clk);
    link_done = 0;
    wait_idle();
    check_header(1'b1, a, len);
    chk(wr_total == 4, "R3 read pushes header only", wr_total, 4);
    chk(go_i2c == !nat && go_na == !nat && go_ns == 0, "R7 read flags",
        {go_i2c, go_na, go_ns}, {!nat, !nat, 1'b0});
    chk(rep_n == len, "R8 reply byte count", rep_n, len);
    chk(rptr == len + 1, "R8 first word discarded", rptr, len + 1);
    for (int k = 0; k < len; k++) begin
      if (rep_buf[k] != 8'(k * 11 + 3)) bad++;
      if (rep_err_buf[k] != (k == bad_pos)) errs++;
    end
    chk(bad == 0, "R8 reply data order", bad, 0);
    chk(errs == 0, "R8 index error flags", errs, 0);
  endtask

  task automatic t_settled(input bit rd, input bit nat, input int len, input bit exp_ack,
                           input string req);
    clear_cap();
    send_req(rd, nat, 1'b0, 1'b0, 20'h12345, len);
    repeat (8) @(negedge clk);
    chk(got_ack == exp_ack && got_ref == !exp_ack, {req, " settle"}, {got_ack, got_ref},
        {exp_ack, !exp_ack});
    chk(wr_total == 0 && go_cnt == 0 && req_ready, {req, " nothing sent"}, wr_total, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write(1'b1, 1'b1, 1'b1, 20'hA_BC12, 5, 1'b0);
    t_write(1'b0, 1'b1, 1'b0, 20'h0_0050, 9, 1'b1);
    t_write(1'b1, 1'b0, 1'b0, 20'hF_0001, 16, 1'b0);
    t_write(1'b0, 1'b0, 1'b1, 20'h5_A5A5, 124, 1'b0);
    t_read(1'b1, 20'h0_0202, 6, -1);
    t_read(1'b0, 20'h3_0050, 128, 70);
    t_read(1'b0, 20'h9_8765, 1, 0);
    t_settled(1'b0, 1'b1, 0, 1'b1, "R6 zero length ack");
    t_settled(1'b0, 1'b1, 17, 1'b0, "R6 native over 16");
    t_settled(1'b1, 1'b0, 129, 1'b0, "R6 i2c over 128");
    t_settled(1'b0, 1'b0, 125, 1'b0, "R4 fifo over 128");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule